// File: doc/BRIEF.md
# Serializing Instruction Release Controller

Some instructions are unsafe to run speculatively: stores, special-register moves, arithmetic that reads the carry flag, and logic on condition fields. This controller tracks such instructions. Each one is dispatched normally but is given a held slot, and its execute-enable stays low. Younger instructions keep dispatching and executing while it waits.

A held instruction is released when it is the oldest pending serialized instruction and the in-order completion pointer reaches its sequence number. At that point every older instruction has committed. Release is a single-cycle pulse on the execute-enable bit of the slot.

While the serialized instruction sits at the head of completion and has not finished, the controller raises a completion stall. This keeps younger, already-executed work from retiring ahead of it. When the released instruction reports that it has finished, the controller issues a one-cycle completion request carrying its sequence number and frees the slot. A flush discards every pending slot.

Top module: `ser_release_ctrl`

## Requirements
- R1: After reset, `exec_en_o`, `cmpl_stall_o`, `cmpl_req_o` and `full_o` are all 0, and `disp_slot_o` is 0.
- R2: A dispatch with `disp_valid_i`=1 and `disp_ser_i`=1 takes the slot shown on `disp_slot_o` in that cycle. Slots are handed out round-robin from 0, and the new entry's `exec_en_o` bit stays 0.
- R3: When the oldest pending entry is held and `cmpl_ptr_i` equals its sequence number at a clock edge, its `exec_en_o` bit is 1 for exactly the cycle after that edge. At most one bit of `exec_en_o` is ever set.
- R4: A dispatch with `disp_ser_i`=0 allocates nothing, so `disp_slot_o` does not advance.
- R5: Serialized entries are released strictly in program order. A held entry is not released while an older serialized entry is still pending, even if `cmpl_ptr_i` equals its sequence number.
- R6: In the same cycle, `cmpl_stall_o` is 1 exactly when an entry is pending, the oldest one is held or released, and its sequence number equals `cmpl_ptr_i`.
- R7: `ser_done_i` while the oldest entry has been released frees that entry. In the next cycle, `cmpl_req_o` is 1 for one cycle and `cmpl_req_seq_o` holds its sequence number.
- R8: `ser_done_i` has no effect while the oldest entry is still held or no entry is pending.
- R9: `full_o` is 1 when all SLOTS slots are pending. A serialized dispatch while full is dropped, and `disp_slot_o` does not advance.
- R10: `flush_i` empties every slot at the next edge. `full_o` drops, `disp_slot_o` returns to 0, no release occurs, and the stall stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all pending entries |
| disp_valid_i | input | 1 | Dispatch slot carries an instruction |
| disp_ser_i | input | 1 | Dispatched instruction must be serialized |
| disp_seq_i | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_slot_o | output | IDX_W | Slot assigned to a serialized dispatch this cycle |
| full_o | output | 1 | All slots pending |
| cmpl_ptr_i | input | SEQ_W | Sequence number of the oldest uncompleted instruction |
| ser_done_i | input | 1 | Released serialized instruction finished execution |
| exec_en_o | output | SLOTS | Per-slot execute-enable pulse |
| cmpl_stall_o | output | 1 | Hold completion at the current pointer |
| cmpl_req_o | output | 1 | Request completion of a finished serialized instruction |
| cmpl_req_seq_o | output | SEQ_W | Sequence number for the completion request |

## Verification
`disp_slot_o`, `full_o` and `cmpl_stall_o` are combinational from the current state and inputs. `exec_en_o` and `cmpl_req_o` are registered, so they appear one edge after the cycle in which the release condition or `ser_done_i` was presented. The bench drives each step on the falling edge and samples 1 ns later. Each row's expected values are therefore the outputs caused by the previous rising edge together with the inputs just applied. The directed part fills the queue, dispatches into the full queue, and flushes with the pointer matching a held entry, so that a missing gate would show as a release or a moved slot pointer.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_HELD = 2'd1,
    SLOT_RUN  = 2'd2
  } slot_state_e;
endpackage

// File: rtl/ser_ptr_ctrl.sv
module ser_ptr_ctrl #(
  parameter int SLOTS = 4,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [IDX_W-1:0] wrap_inc(logic [IDX_W-1:0] p);
    return (p == IDX_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= wrap_inc(tail_q);
      if (pop_i)  head_q <= wrap_inc(head_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (count_q == CNT_W'(SLOTS));

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> count_q != CNT_W'(SLOTS)); // R9
endmodule

// File: rtl/ser_entry.sv
module ser_entry
  import ser_pkg::*;
#(
  parameter int SEQ_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             alloc_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic             release_i,
  input  logic             free_i,
  output logic             held_o,
  output logic             run_o,
  output logic [SEQ_W-1:0] seq_o
);
  slot_state_e      state_q;
  logic [SEQ_W-1:0] seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SLOT_FREE;
      seq_q   <= '0;
    end else if (flush_i) begin
      state_q <= SLOT_FREE;
    end else if (alloc_i) begin
      state_q <= SLOT_HELD;
      seq_q   <= seq_i;
    end else if (release_i) begin
      state_q <= SLOT_RUN;
    end else if (free_i) begin
      state_q <= SLOT_FREE;
    end
  end

  assign held_o = (state_q == SLOT_HELD);
  assign run_o  = (state_q == SLOT_RUN);
  assign seq_o  = seq_q;

  AST_ALLOC_FREE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> state_q == SLOT_FREE); // R9
  AST_RELEASE_HELD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> state_q == SLOT_HELD); // R5
  AST_FREE_RUN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> state_q == SLOT_RUN); // R8
endmodule

// File: rtl/ser_release_ctrl.sv
module ser_release_ctrl #(
  parameter int SEQ_W = 6,
  parameter int SLOTS = 4,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             disp_valid_i,
  input  logic             disp_ser_i,
  input  logic [SEQ_W-1:0] disp_seq_i,
  output logic [IDX_W-1:0] disp_slot_o,
  output logic             full_o,
  input  logic [SEQ_W-1:0] cmpl_ptr_i,
  input  logic             ser_done_i,
  output logic [SLOTS-1:0] exec_en_o,
  output logic             cmpl_stall_o,
  output logic             cmpl_req_o,
  output logic [SEQ_W-1:0] cmpl_req_seq_o
);
  logic [IDX_W-1:0] head, tail;
  logic             full;
  logic [SLOTS-1:0] held_v, run_v;
  logic [SEQ_W-1:0] seq_a [SLOTS];
  logic             push, pop, rel_fire;
  logic             head_held, head_run;
  logic [SEQ_W-1:0] head_seq;
  logic [SLOTS-1:0] exec_en_q;
  logic             cmpl_req_q;
  logic [SEQ_W-1:0] cmpl_req_seq_q;

  ser_ptr_ctrl #(.SLOTS(SLOTS)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .push_i (push),
    .pop_i  (pop),
    .head_o (head),
    .tail_o (tail),
    .full_o (full)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    ser_entry #(.SEQ_W(SEQ_W)) u_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .flush_i  (flush_i),
      .alloc_i  (push && (tail == IDX_W'(g))),
      .seq_i    (disp_seq_i),
      .release_i(rel_fire && (head == IDX_W'(g))),
      .free_i   (pop && (head == IDX_W'(g))),
      .held_o   (held_v[g]),
      .run_o    (run_v[g]),
      .seq_o    (seq_a[g])
    );
  end

  assign head_held = held_v[head];
  assign head_run  = run_v[head];
  assign head_seq  = seq_a[head];

  // only the oldest entry is ever a release candidate: program order
  assign rel_fire = !flush_i && head_held && (head_seq == cmpl_ptr_i);
  assign push     = !flush_i && disp_valid_i && disp_ser_i && !full;
  assign pop      = !flush_i && ser_done_i && head_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_en_q      <= '0;
      cmpl_req_q     <= 1'b0;
      cmpl_req_seq_q <= '0;
    end else begin
      exec_en_q  <= rel_fire ? (SLOTS'(1) << head) : '0;
      cmpl_req_q <= pop;
      if (pop) cmpl_req_seq_q <= head_seq;
    end
  end

  assign disp_slot_o    = tail;
  assign full_o         = full;
  assign exec_en_o      = exec_en_q;
  assign cmpl_stall_o   = (head_held || head_run) && (head_seq == cmpl_ptr_i);
  assign cmpl_req_o     = cmpl_req_q;
  assign cmpl_req_seq_o = cmpl_req_seq_q;

  AST_EXEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(exec_en_q)); // R3
  AST_EXEC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|exec_en_q) |=> ((exec_en_q & $past(exec_en_q)) == '0)); // R3
  AST_EXEC_AT_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|exec_en_q) |-> $past(cmpl_ptr_i) == $past(head_seq)); // R3
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_req_q |=> !cmpl_req_q); // R7
  AST_FLUSH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!full && exec_en_q == '0 && !cmpl_req_q && !cmpl_stall_o)); // R10
endmodule

// File: tb/ser_release_ctrl_bench.sv
module ser_release_ctrl_bench;
  localparam int SEQ_W = 6;
  localparam int SLOTS = 4;

  typedef struct packed {
    logic       fl, dv, ds;
    logic [5:0] dseq, cptr;
    logic       done;
    logic [3:0] e_exec;
    logic [1:0] e_slot;
    logic       e_stall, e_req;
    logic [5:0] e_rseq;
    logic       e_full;
  } vec_t;

  // expected = outputs seen with this row's inputs, after the previous edge
  localparam vec_t VEC [12] = '{
    '{1'b0,1'b1,1'b1,6'd5,6'd3,1'b0, 4'd0,2'd0,1'b0,1'b0,6'd0,1'b0}, // R2 alloc seq5
    '{1'b0,1'b1,1'b0,6'd6,6'd3,1'b0, 4'd0,2'd1,1'b0,1'b0,6'd0,1'b0}, // R4 plain dispatch
    '{1'b0,1'b1,1'b1,6'd7,6'd4,1'b0, 4'd0,2'd1,1'b0,1'b0,6'd0,1'b0}, // R2 alloc seq7
    '{1'b0,1'b0,1'b0,6'd0,6'd5,1'b0, 4'd0,2'd2,1'b1,1'b0,6'd0,1'b0}, // R6 stall
    '{1'b0,1'b0,1'b0,6'd0,6'd5,1'b0, 4'd1,2'd2,1'b1,1'b0,6'd0,1'b0}, // R3 release slot0
    '{1'b0,1'b0,1'b0,6'd0,6'd5,1'b0, 4'd0,2'd2,1'b1,1'b0,6'd0,1'b0}, // R3 single pulse
    '{1'b0,1'b0,1'b0,6'd0,6'd7,1'b0, 4'd0,2'd2,1'b0,1'b0,6'd0,1'b0}, // R5 younger ptr
    '{1'b0,1'b0,1'b0,6'd0,6'd7,1'b0, 4'd0,2'd2,1'b0,1'b0,6'd0,1'b0}, // R5 not released
    '{1'b0,1'b0,1'b0,6'd0,6'd5,1'b1, 4'd0,2'd2,1'b1,1'b0,6'd0,1'b0}, // R7 done
    '{1'b0,1'b0,1'b0,6'd0,6'd6,1'b0, 4'd0,2'd2,1'b0,1'b1,6'd5,1'b0}, // R7 request
    '{1'b0,1'b0,1'b0,6'd0,6'd7,1'b1, 4'd0,2'd2,1'b1,1'b0,6'd0,1'b0}, // R8 done on held
    '{1'b0,1'b0,1'b0,6'd0,6'd7,1'b0, 4'd2,2'd2,1'b1,1'b0,6'd0,1'b0}  // R8 ignored, R3 slot1
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush, dv, ds, done;
  logic [SEQ_W-1:0] dseq, cptr;
  logic [1:0]       slot;
  logic             full, stall, req;
  logic [3:0]       exec_en;
  logic [SEQ_W-1:0] rseq;
  int               n_chk = 0;
  int               n_fail = 0;
  bit               finished = 1'b0;

  always #5 clk = ~clk;

  ser_release_ctrl #(.SEQ_W(SEQ_W), .SLOTS(SLOTS)) u_ser_release_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .disp_valid_i(dv), .disp_ser_i(ds), .disp_seq_i(dseq),
    .disp_slot_o(slot), .full_o(full), .cmpl_ptr_i(cptr),
    .ser_done_i(done), .exec_en_o(exec_en), .cmpl_stall_o(stall),
    .cmpl_req_o(req), .cmpl_req_seq_o(rseq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic v, input logic s,
                       input int sq, input int cp, input logic d);
    @(negedge clk);
    flush = f; dv = v; ds = s; dseq = SEQ_W'(sq); cptr = SEQ_W'(cp); done = d;
    #1;
  endtask

  initial begin
    flush = 0; dv = 0; ds = 0; dseq = '0; cptr = '0; done = 0;
    #1;
    chk("R1 exec_en", int'(exec_en), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 stall", int'(stall), 0);
    chk("R1 req", int'(req), 0);
    chk("R1 slot", int'(slot), 0);
    #20 rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      drive(VEC[i].fl, VEC[i].dv, VEC[i].ds, int'(VEC[i].dseq), int'(VEC[i].cptr), VEC[i].done);
      chk($sformatf("R3/R5 exec_en row%0d", i), int'(exec_en), int'(VEC[i].e_exec));
      chk($sformatf("R2/R4 slot row%0d", i), int'(slot), int'(VEC[i].e_slot));
      chk($sformatf("R6 stall row%0d", i), int'(stall), int'(VEC[i].e_stall));
      chk($sformatf("R7/R8 req row%0d", i), int'(req), int'(VEC[i].e_req));
      if (VEC[i].e_req) chk($sformatf("R7 req_seq row%0d", i), int'(rseq), int'(VEC[i].e_rseq));
      chk($sformatf("R9 full row%0d", i), int'(full), int'(VEC[i].e_full));
    end

    // R9: fill remaining slots (slot1 running seq7; push into 2,3,0)
    drive(0, 1, 1, 10, 7, 0);
    drive(0, 1, 1, 11, 7, 0);
    drive(0, 1, 1, 12, 7, 0);
    drive(0, 1, 1, 13, 7, 0);   // attempt while full
    chk("R9 full set", int'(full), 1);
    chk("R9 slot wrapped", int'(slot), 1);
    drive(0, 0, 0, 0, 7, 1);    // done on running head
    chk("R9 still full before pop", int'(full), 1);
    drive(0, 0, 0, 0, 9, 0);
    chk("R9 full cleared", int'(full), 0);
    chk("R9 dropped dispatch", int'(slot), 1);
    chk("R7 req after done", int'(req), 1);
    chk("R7 req seq", int'(rseq), 7);

    // R10: flush while pointer matches held head seq10
    drive(1, 0, 0, 0, 10, 0);
    chk("R10 stall before flush", int'(stall), 1);
    drive(0, 0, 0, 0, 10, 0);
    chk("R10 full", int'(full), 0);
    chk("R10 slot", int'(slot), 0);
    chk("R10 stall", int'(stall), 0);
    chk("R10 no release", int'(exec_en), 0);
    drive(0, 0, 0, 0, 10, 0);
    chk("R10 no late release", int'(exec_en), 0);
    chk("R8 done idle", int'(req), 0);
    drive(0, 0, 0, 0, 10, 1);   // done with nothing pending
    drive(0, 0, 0, 0, 10, 0);
    chk("R8 done empty ignored", int'(req), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule